// File: doc/BRIEF.md
# Latched Bidirectional Bus Transceiver

This block passes data between two ports, A and B, through two banks of level-sensitive storage, one per transfer direction. The data width is split into independent sections of equal width. Each section has three active-low controls per direction: a chip select, a latch-open control and a drive control. When a direction's latch is open, its stored word follows the source port. When the latch closes, the stored word stays as it was. The destination port shows the latch content whenever that direction is selected and its drive control is low.

The storage is emulated synchronously, so the block needs no real latches or internal tri-states. Each lane has two modes, FOLLOW and HOLD, and both are decoded from the lane's controls:
- FOLLOW: chip select low and latch-open low. The destination output is a combinational copy of the source input. The storage register copies the source on every rising clock edge.
- HOLD: any other combination. The destination output shows the storage register, which does not change.

There are two transitions. FOLLOW→HOLD happens when latch-open rises or when chip select rises. HOLD→FOLLOW happens when both controls are low again. Each port is presented as a data output plus one drive flag per section. A wrapper can merge these into real inout pins.

Top module: `latched_xcvr`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, both storage banks hold zero. A lane that is selected with its latch closed and its drive on outputs 0.
- R2: While a section's A-to-B chip select and latch-open are both low, `b_out` for that section equals `a_in` in the same cycle.
- R3: When latch-open rises while chip select stays low, the lane keeps the source value sampled at the last rising clock edge at which the lane was in FOLLOW. Later changes to the source do not reach the output.
- R4: When chip select rises while latch-open is low, the latch closes. The stored value stays unchanged while chip select is high, and it is shown again once chip select drops with latch-open high.
- R5: A section's destination drive flag is 1 only when that direction's chip select and drive control are both low. The flag is 0 if either is high, whatever the latch-open control is.
- R6: The B-to-A direction behaves like A-to-B. It uses its own controls, takes `b_in` as its source and drives `a_out`/`a_oe`.
- R7: Sections are independent. Bits [7:0] belong to section 0 (control bit 0) and bits [15:8] to section 1 (control bit 1). Controls of one section never affect the data or flags of the other section.
- R8: The two directions keep separate storage, so both banks can hold different words at the same time.
- R9: While the drive control is high, an open latch still captures its source. That value appears once the drive control is turned on.
- R10: In correct use, the two directions of one section never drive at the same time. Simultaneous `a_oe` and `b_oe` in a section is bus contention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at which open latches sample their source |
| rst_n | input | 1 | Asynchronous active-low reset, clears both banks |
| a_in | input | 16 | Data arriving on the A port |
| b_in | input | 16 | Data arriving on the B port |
| ab_sel_n | input | 2 | A-to-B chip select per section, active low |
| ab_open_n | input | 2 | A-to-B latch-open per section, active low |
| ab_drv_n | input | 2 | A-to-B drive control per section, active low |
| ba_sel_n | input | 2 | B-to-A chip select per section, active low |
| ba_open_n | input | 2 | B-to-A latch-open per section, active low |
| ba_drv_n | input | 2 | B-to-A drive control per section, active low |
| a_out | output | 16 | Data driven onto the A port |
| a_oe | output | 2 | Per-section drive flag for the A port |
| b_out | output | 16 | Data driven onto the B port |
| b_oe | output | 2 | Per-section drive flag for the B port |

## Verification
The contention assertion assumes that the controls never enable both directions of a section at once. The stimulus only ever selects and drives one direction of a section in each step. The hold-stability assertion assumes that data and controls change only between clock edges, away from the capturing edge. The bench changes every input at the falling edge and reads outputs one time unit later.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic {
        LANE_HOLD   = 1'b0,
        LANE_FOLLOW = 1'b1
    } lane_mode_e;
endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_n,
    input  logic         open_n,
    input  logic         drv_n,
    input  logic [W-1:0] src,
    output logic [W-1:0] dst,
    output logic         dst_oe
);
    lane_mode_e    mode;
    logic [W-1:0]  store_q;

    // Mode decode: chip select gates the latch-open control
    always_comb begin
        mode = (!sel_n && !open_n) ? LANE_FOLLOW : LANE_HOLD;
    end

    // Storage register: copies the source while the lane follows
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            unique case (mode)
                LANE_FOLLOW: store_q <= src;
                LANE_HOLD:   store_q <= store_q;
            endcase
        end
    end

    // Outputs: pass-through when following, stored word otherwise
    always_comb begin
        unique case (mode)
            LANE_FOLLOW: dst = src;
            LANE_HOLD:   dst = store_q;
        endcase
        dst_oe = !sel_n && !drv_n;
    end
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_sel_n,
    input  logic         ab_open_n,
    input  logic         ab_drv_n,
    input  logic         ba_sel_n,
    input  logic         ba_open_n,
    input  logic         ba_drv_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    xcvr_lane #(.W(W)) u_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (ab_sel_n),
        .open_n (ab_open_n),
        .drv_n  (ab_drv_n),
        .src    (a_in),
        .dst    (b_out),
        .dst_oe (b_oe)
    );

    xcvr_lane #(.W(W)) u_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (ba_sel_n),
        .open_n (ba_open_n),
        .drv_n  (ba_drv_n),
        .src    (b_in),
        .dst    (a_out),
        .dst_oe (a_oe)
    );
endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr #(
    parameter int SECT_W = 8,
    parameter int N_SECT = 2,
    localparam int BUS_W = SECT_W * N_SECT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  a_in,
    input  logic [BUS_W-1:0]  b_in,
    input  logic [N_SECT-1:0] ab_sel_n,
    input  logic [N_SECT-1:0] ab_open_n,
    input  logic [N_SECT-1:0] ab_drv_n,
    input  logic [N_SECT-1:0] ba_sel_n,
    input  logic [N_SECT-1:0] ba_open_n,
    input  logic [N_SECT-1:0] ba_drv_n,
    output logic [BUS_W-1:0]  a_out,
    output logic [N_SECT-1:0] a_oe,
    output logic [BUS_W-1:0]  b_out,
    output logic [N_SECT-1:0] b_oe
);
    for (genvar s = 0; s < N_SECT; s++) begin : g_sect
        xcvr_section #(.W(SECT_W)) u_sect (
            .clk       (clk),
            .rst_n     (rst_n),
            .a_in      (a_in[s*SECT_W +: SECT_W]),
            .b_in      (b_in[s*SECT_W +: SECT_W]),
            .ab_sel_n  (ab_sel_n[s]),
            .ab_open_n (ab_open_n[s]),
            .ab_drv_n  (ab_drv_n[s]),
            .ba_sel_n  (ba_sel_n[s]),
            .ba_open_n (ba_open_n[s]),
            .ba_drv_n  (ba_drv_n[s]),
            .a_out     (a_out[s*SECT_W +: SECT_W]),
            .a_oe      (a_oe[s]),
            .b_out     (b_out[s*SECT_W +: SECT_W]),
            .b_oe      (b_oe[s])
        );
    end
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int SECT_W = 8,
    parameter int N_SECT = 2,
    localparam int BUS_W = SECT_W * N_SECT
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_W-1:0]  a_in,
    input logic [BUS_W-1:0]  b_in,
    input logic [N_SECT-1:0] ab_sel_n,
    input logic [N_SECT-1:0] ab_open_n,
    input logic [N_SECT-1:0] ab_drv_n,
    input logic [N_SECT-1:0] ba_sel_n,
    input logic [N_SECT-1:0] ba_open_n,
    input logic [N_SECT-1:0] ba_drv_n,
    input logic [BUS_W-1:0]  a_out,
    input logic [N_SECT-1:0] a_oe,
    input logic [BUS_W-1:0]  b_out,
    input logic [N_SECT-1:0] b_oe
);
    for (genvar s = 0; s < N_SECT; s++) begin : g_chk
        logic ab_closed, ba_closed;
        assign ab_closed = ab_sel_n[s] || ab_open_n[s];
        assign ba_closed = ba_sel_n[s] || ba_open_n[s];

        // R2: open latch passes the A side straight to B
        a_r2_follow: assert property (@(posedge clk) disable iff (!rst_n)
            (!ab_sel_n[s] && !ab_open_n[s]) |->
                (b_out[s*SECT_W +: SECT_W] == a_in[s*SECT_W +: SECT_W]));

        // R3 / R4: a closed latch holds its word across cycles
        a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (ab_closed && $past(ab_closed)) |->
                $stable(b_out[s*SECT_W +: SECT_W]));

        // R6: same hold rule on the B-to-A lane
        a_r6_hold_stable_ba: assert property (@(posedge clk) disable iff (!rst_n)
            (ba_closed && $past(ba_closed)) |->
                $stable(a_out[s*SECT_W +: SECT_W]));

        // R5: a deselected direction never drives
        a_r5_sel_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
            (ab_sel_n[s] || ab_drv_n[s]) |-> !b_oe[s]);

        // R6: same drive rule for B-to-A
        a_r6_sel_blocks_drive_ba: assert property (@(posedge clk) disable iff (!rst_n)
            (ba_sel_n[s] || ba_drv_n[s]) |-> !a_oe[s]);

        // R10: correct use never drives both ports of one section
        a_r10_no_dual_drive: assert property (@(posedge clk) disable iff (!rst_n)
            !(a_oe[s] && b_oe[s]));
    end
endmodule

bind latched_xcvr xcvr_checker #(.SECT_W(SECT_W), .N_SECT(N_SECT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_in      (a_in),
    .b_in      (b_in),
    .ab_sel_n  (ab_sel_n),
    .ab_open_n (ab_open_n),
    .ab_drv_n  (ab_drv_n),
    .ba_sel_n  (ba_sel_n),
    .ba_open_n (ba_open_n),
    .ba_drv_n  (ba_drv_n),
    .a_out     (a_out),
    .a_oe      (a_oe),
    .b_out     (b_out),
    .b_oe      (b_oe)
);

// File: tb/sim_latched_xcvr.sv
`timescale 1ns/1ps
module sim_latched_xcvr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0, b_in = '0;
    logic [1:0]  ab_sel_n = '1, ab_open_n = '1, ab_drv_n = '1;
    logic [1:0]  ba_sel_n = '1, ba_open_n = '1, ba_drv_n = '1;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_oe, b_oe;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    latched_xcvr u0 (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .ab_sel_n(ab_sel_n), .ab_open_n(ab_open_n), .ab_drv_n(ab_drv_n),
        .ba_sel_n(ba_sel_n), .ba_open_n(ba_open_n), .ba_drv_n(ba_drv_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ab_sel_n = '1; ab_open_n = '1; ab_drv_n = '1;
        ba_sel_n = '1; ba_open_n = '1; ba_drv_n = '1;
    endtask

    // R10 contention monitor
    always @(negedge clk) begin
        #2;
        if (rst_n && ((a_oe & b_oe) != 2'b00)) begin
            fails++;
            $display("FAIL R10: actual a_oe&b_oe=%b expected 00", a_oe & b_oe);
        end
    end

    task automatic t_reset();
        @(negedge clk);
        ab_sel_n = 2'b00; ab_open_n = 2'b11; ab_drv_n = 2'b00;
        #1;
        check("R1 b_out", b_out, 16'h0000);
        check("R1 b_oe", {14'd0, b_oe}, 16'h0003);
        idle();
        ba_sel_n = 2'b00; ba_drv_n = 2'b00;
        #1;
        check("R1 a_out", a_out, 16'h0000);
        idle();
    endtask

    task automatic t_follow();
        @(negedge clk);
        ab_sel_n = 2'b00; ab_open_n = 2'b00; ab_drv_n = 2'b00;
        a_in = 16'h1234;
        #1 check("R2 follow1", b_out, 16'h1234);
        @(negedge clk);
        a_in = 16'hBEEF;
        #1 check("R2 follow2", b_out, 16'hBEEF);
    endtask

    task automatic t_hold();
        @(negedge clk);
        a_in = 16'hA55A;
        @(negedge clk);
        ab_open_n = 2'b11; a_in = 16'h0F0F;
        #1 check("R3 hold", b_out, 16'hA55A);
        @(negedge clk);
        a_in = 16'hFFFF;
        #1 check("R3 hold later", b_out, 16'hA55A);
        idle();
    endtask

    task automatic t_sel_close();
        @(negedge clk);
        ab_sel_n = 2'b00; ab_open_n = 2'b00; a_in = 16'h3C3C;
        @(negedge clk);
        ab_sel_n = 2'b11; a_in = 16'h9999;
        @(negedge clk);
        a_in = 16'h7777;
        @(negedge clk);
        ab_sel_n = 2'b00; ab_open_n = 2'b11; ab_drv_n = 2'b00;
        #1 check("R4 sel close", b_out, 16'h3C3C);
        idle();
    endtask

    task automatic t_drive();
        @(negedge clk);
        ab_sel_n = 2'b11; ab_open_n = 2'b00; ab_drv_n = 2'b00;
        #1 check("R5 sel high", {14'd0, b_oe}, 16'h0000);
        @(negedge clk);
        ab_sel_n = 2'b00; ab_drv_n = 2'b11;
        #1 check("R5 drv high", {14'd0, b_oe}, 16'h0000);
        @(negedge clk);
        ab_drv_n = 2'b10;
        #1 check("R5 partial", {14'd0, b_oe}, 16'h0001);
        idle();
    endtask

    task automatic t_capture_off();
        @(negedge clk);
        ab_sel_n = 2'b00; ab_open_n = 2'b00; ab_drv_n = 2'b11; a_in = 16'h5AA5;
        @(negedge clk);
        ab_open_n = 2'b11; a_in = 16'h0000;
        @(negedge clk);
        ab_drv_n = 2'b00;
        #1 check("R9 capture while off", b_out, 16'h5AA5);
        idle();
    endtask

    task automatic t_b2a();
        @(negedge clk);
        ba_sel_n = 2'b00; ba_open_n = 2'b00; ba_drv_n = 2'b00; b_in = 16'hC0DE;
        #1 check("R6 follow", a_out, 16'hC0DE);
        check("R6 oe", {14'd0, a_oe}, 16'h0003);
        @(negedge clk);
        ba_open_n = 2'b11; b_in = 16'h1111;
        #1 check("R6 hold", a_out, 16'hC0DE);
        idle();
    endtask

    task automatic t_sections();
        // load section0 with 0x22, section1 stays at earlier value then gets 0x44
        @(negedge clk);
        ab_sel_n = 2'b00; ab_open_n = 2'b10; a_in = 16'h4422;
        @(negedge clk);
        ab_open_n = 2'b11; a_in = 16'h0000;
        @(negedge clk);
        ab_sel_n = 2'b00; ab_open_n = 2'b01; ab_drv_n = 2'b00; a_in = 16'h4466;
        #1 check("R7 sect independent", b_out, 16'h4422);
        idle();
    endtask

    task automatic t_both_banks();
        @(negedge clk);
        ab_sel_n = 2'b00; ab_open_n = 2'b00; a_in = 16'h1357;
        ba_sel_n = 2'b00; ba_open_n = 2'b00; b_in = 16'h2468;
        @(negedge clk);
        ab_open_n = 2'b11; ba_open_n = 2'b11;
        a_in = 16'h0; b_in = 16'h0;
        @(negedge clk);
        ab_drv_n = 2'b00;
        ba_sel_n = 2'b11;
        #1 check("R8 ab bank", b_out, 16'h1357);
        @(negedge clk);
        ab_sel_n = 2'b11; ab_drv_n = 2'b11;
        ba_sel_n = 2'b00; ba_drv_n = 2'b00;
        #1 check("R8 ba bank", a_out, 16'h2468);
        check("R10 single drive", {14'd0, a_oe & b_oe}, 16'h0000);
        idle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_follow();
        t_hold();
        t_sel_close();
        t_drive();
        t_capture_off();
        t_b2a();
        t_sections();
        t_both_banks();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule